// File: doc/BRIEF.md
# Serial EEPROM configuration loader

This block brings the chip's configuration registers up from an external serial EEPROM. It starts when the active-low reset is released. It reads a small image through a shared SMBus master engine and turns each record of that image into a one-cycle write on a register-write port. The register file keeps its default values until these writes arrive. An 8-bit checksum closes the image. If the checksum does not match, or the EEPROM stops acknowledging, the block raises an error flag and pulses a restore-defaults strobe.

The loader talks to the engine in whole transactions. For each transaction it holds a request together with the device address, the direction, the byte count, the EEPROM memory offset and the write byte. The engine streams read bytes back, one strobe each. It then ends the transaction with a completion strobe that carries an acknowledge-failure flag. The device address is taken from strap pins when reset is released. A build option replaces the straps with a fixed address.

Once loading has finished, a management agent can read or write single EEPROM bytes through a pass-through port. This allows the image to be reprogrammed in the system.

Top module: `cfg_image_loader`

## Requirements
- R1: `rst_n` is a synchronous active-low reset. While it is low, `smb_req`, `reg_we`, `restore_defaults`, `ld_done`, `ld_err` and `mgmt_ack` are 0. At the first clock edge that samples `rst_n` high, the loader raises `smb_req` to start loading.
- R2: With `HAS_STRAPS`=1, `smb_dev` takes the value of `strap_dev` sampled on the last reset cycle. Later changes of `strap_dev` have no effect on `smb_dev` until the next reset.
- R3: With `HAS_STRAPS`=0, `smb_dev` is always `FIXED_DEV` (default 7'h50).
- R4: Image layout and read order. Byte offset 0 holds a 16-bit record count N, most significant byte first. Record i sits at offset 2+6i and holds a 16-bit register address, then 32-bit data, both most significant byte first. The checksum byte sits at offset 2+6N. All loading transactions are reads (`smb_rnw`=1). The header read has count 2 at offset 0, each record read has count 6 at its offset, and the checksum read has count 1.
- R5: Each completed record read produces exactly one `reg_we` pulse one cycle after its `smb_done`, carrying the record's address on `reg_addr` and its data on `reg_wdata`. No `reg_we` occurs once `ld_done` is high.
- R6: The checksum is valid when the 8-bit sum of all image bytes, the checksum byte included, is zero. In that case `ld_done` rises one cycle after the checksum read completes, `ld_err` stays 0 and no restore pulse occurs. `ld_done` then stays high until reset.
- R7: On a checksum mismatch, `ld_done` and `ld_err` rise one cycle after the checksum read completes, and `restore_defaults` pulses for exactly that one cycle.
- R8: If the engine reports no acknowledge (`smb_nak`=1 with `smb_done`) during loading, the loader issues no further loading request and no register write for that record. One cycle later `ld_done` and `ld_err` rise and `restore_defaults` pulses once.
- R9: With N=0, the read following the header is the checksum read at offset 2.
- R10: `mgmt_req` is not served before `ld_done`. After that, a held read request (`mgmt_we`=0) issues one read with count 1 at `mgmt_offs`. `mgmt_ack` pulses one cycle after that read's `smb_done`, with the byte on `mgmt_rdata`.
- R11: A pass-through write (`mgmt_we`=1) issues one transaction with `smb_rnw`=0, count 1, offset `mgmt_offs` and `smb_wdata`=`mgmt_wdata`. On any pass-through, `mgmt_nak` at the `mgmt_ack` pulse repeats the engine's `smb_nak`.
- R12: While `smb_req` is high and no `smb_done` has arrived, `smb_req`, `smb_offs`, `smb_cnt` and `smb_rnw` stay unchanged. `smb_req` falls one cycle after `smb_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loading starts when it is released |
| strap_dev | input | DEV_W | Address straps, sampled during reset |
| smb_req | output | 1 | Transaction request to the SMBus engine, held until completion |
| smb_dev | output | DEV_W | EEPROM device address |
| smb_rnw | output | 1 | 1 = read, 0 = write |
| smb_cnt | output | CNT_W | Number of data bytes in the transaction |
| smb_offs | output | OFFS_W | EEPROM memory offset |
| smb_wdata | output | 8 | Byte to write |
| smb_rvalid | input | 1 | Read byte strobe from the engine |
| smb_rdata | input | 8 | Read byte |
| smb_done | input | 1 | Transaction completion strobe |
| smb_nak | input | 1 | Acknowledge failure, valid with smb_done |
| reg_we | output | 1 | Configuration register write strobe |
| reg_addr | output | RADDR_W | Register address |
| reg_wdata | output | RDATA_W | Register data |
| restore_defaults | output | 1 | One-cycle pulse asking the register file to restore defaults |
| ld_done | output | 1 | Loading finished (successfully or not) |
| ld_err | output | 1 | Loading failed (checksum or no acknowledge) |
| mgmt_req | input | 1 | Pass-through request, held until mgmt_ack |
| mgmt_we | input | 1 | Pass-through direction, 1 = write |
| mgmt_offs | input | OFFS_W | Pass-through EEPROM offset |
| mgmt_wdata | input | 8 | Pass-through write byte |
| mgmt_ack | output | 1 | Pass-through completion pulse |
| mgmt_rdata | output | 8 | Pass-through read byte |
| mgmt_nak | output | 1 | Pass-through acknowledge failure |

## Verification
Every result is due a fixed number of cycles after the engine strobe that causes it. The first request appears one cycle after reset release. A register write, the done, error and restore flags, and the pass-through acknowledge each appear one cycle after the `smb_done` that completes their transaction. The bench models the EEPROM engine and the expected outputs behaviourally. It drives every strobe and samples every output on the falling clock edge. Each completion strobe schedules its expectations for exactly the next falling edge, and all outputs are compared against these expectations on every clock. This means an early or late output is counted as a mismatch, not only a wrong value.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_WAIT,
    ST_NEXT,
    ST_IDLE,
    ST_PT
  } ldr_state_t;

  typedef enum logic [1:0] {
    PH_HDR,
    PH_REC,
    PH_SUM
  } ldr_phase_t;

endpackage

// File: rtl/cfg_ldr_devaddr.sv
module cfg_ldr_devaddr #(
  parameter bit                HAS_STRAPS = 1'b1,
  parameter int                DEV_W      = 7,
  parameter logic [DEV_W-1:0]  FIXED_DEV  = 7'h50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEV_W-1:0] strap_dev,
  output logic [DEV_W-1:0] dev
);

  generate
    if (HAS_STRAPS) begin : g_strap
      logic [DEV_W-1:0] dev_q;
      // follow the straps during reset, freeze on release
      always_ff @(posedge clk) begin
        if (!rst_n) dev_q <= strap_dev;
      end
      assign dev = dev_q;

      p_dev_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(dev_q));
    end else begin : g_fixed
      assign dev = FIXED_DEV;
    end
  endgenerate

endmodule

// File: rtl/cfg_ldr_shift.sv
module cfg_ldr_shift #(
  parameter int SH_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [7:0]      din,
  output logic [SH_W-1:0] sh
);

  // bytes arrive most significant first, so they enter at the bottom
  always_ff @(posedge clk) begin
    if (!rst_n)  sh <= '0;
    else if (en) sh <= {sh[SH_W-9:0], din};
  end

endmodule

// File: rtl/cfg_ldr_csum.sv
module cfg_ldr_csum (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [7:0] din,
  output logic       zero
);

  logic [7:0] sum_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  sum_q <= '0;
    else if (en) sum_q <= sum_q + din;
  end

  assign zero = (sum_q == 8'h00);

endmodule

// File: rtl/cfg_ldr_seq.sv
module cfg_ldr_seq
  import cfg_ldr_pkg::*;
#(
  parameter int OFFS_W  = 16,
  parameter int CNT_W   = 3,
  parameter int RCNT_W  = 16,
  parameter int RADDR_W = 16,
  parameter int RDATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  // engine side
  output logic               smb_req,
  output logic               smb_rnw,
  output logic [CNT_W-1:0]   smb_cnt,
  output logic [OFFS_W-1:0]  smb_offs,
  output logic [7:0]         smb_wdata,
  input  logic               smb_rvalid,
  input  logic               smb_done,
  input  logic               smb_nak,
  // assembled fields
  input  logic [RCNT_W-1:0]  hdr_count,
  input  logic [RADDR_W-1:0] rec_addr,
  input  logic [RDATA_W-1:0] rec_data,
  input  logic [7:0]         rx_byte,
  input  logic               csum_zero,
  output logic               load_rx,
  // register file side
  output logic               reg_we,
  output logic [RADDR_W-1:0] reg_addr,
  output logic [RDATA_W-1:0] reg_wdata,
  output logic               restore_defaults,
  output logic               ld_done,
  output logic               ld_err,
  // management pass-through
  input  logic               mgmt_req,
  input  logic               mgmt_we,
  input  logic [OFFS_W-1:0]  mgmt_offs,
  input  logic [7:0]         mgmt_wdata,
  output logic               mgmt_ack,
  output logic [7:0]         mgmt_rdata,
  output logic               mgmt_nak
);

  localparam int HDR_BYTES = RCNT_W / 8;
  localparam int REC_BYTES = (RADDR_W + RDATA_W) / 8;

  ldr_state_t          st_q;
  ldr_phase_t          ph_q;
  logic [RCNT_W-1:0]   left_q;
  logic [OFFS_W-1:0]   next_offs_q;

  // only loading reads feed the checksum
  assign load_rx = smb_rvalid && (st_q == ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q             <= ST_BOOT;
      ph_q             <= PH_HDR;
      left_q           <= '0;
      next_offs_q      <= OFFS_W'(HDR_BYTES);
      smb_req          <= 1'b0;
      smb_rnw          <= 1'b1;
      smb_cnt          <= '0;
      smb_offs         <= '0;
      smb_wdata        <= '0;
      reg_we           <= 1'b0;
      reg_addr         <= '0;
      reg_wdata        <= '0;
      restore_defaults <= 1'b0;
      ld_done          <= 1'b0;
      ld_err           <= 1'b0;
      mgmt_ack         <= 1'b0;
      mgmt_rdata       <= '0;
      mgmt_nak         <= 1'b0;
    end else begin
      reg_we           <= 1'b0;
      restore_defaults <= 1'b0;
      mgmt_ack         <= 1'b0;
      case (st_q)
        ST_BOOT: begin
          smb_req  <= 1'b1;
          smb_rnw  <= 1'b1;
          smb_cnt  <= CNT_W'(HDR_BYTES);
          smb_offs <= '0;
          ph_q     <= PH_HDR;
          st_q     <= ST_WAIT;
        end
        ST_WAIT: begin
          if (smb_done) begin
            smb_req <= 1'b0;
            if (smb_nak) begin
              ld_done          <= 1'b1;
              ld_err           <= 1'b1;
              restore_defaults <= 1'b1;
              st_q             <= ST_IDLE;
            end else begin
              case (ph_q)
                PH_HDR: begin
                  left_q <= hdr_count;
                  st_q   <= ST_NEXT;
                end
                PH_REC: begin
                  reg_we      <= 1'b1;
                  reg_addr    <= rec_addr;
                  reg_wdata   <= rec_data;
                  left_q      <= left_q - RCNT_W'(1);
                  next_offs_q <= next_offs_q + OFFS_W'(REC_BYTES);
                  st_q        <= ST_NEXT;
                end
                default: begin
                  ld_done <= 1'b1;
                  if (!csum_zero) begin
                    ld_err           <= 1'b1;
                    restore_defaults <= 1'b1;
                  end
                  st_q <= ST_IDLE;
                end
              endcase
            end
          end
        end
        ST_NEXT: begin
          smb_req  <= 1'b1;
          smb_rnw  <= 1'b1;
          smb_offs <= next_offs_q;
          if (left_q != '0) begin
            smb_cnt <= CNT_W'(REC_BYTES);
            ph_q    <= PH_REC;
          end else begin
            smb_cnt <= CNT_W'(1);
            ph_q    <= PH_SUM;
          end
          st_q <= ST_WAIT;
        end
        ST_IDLE: begin
          if (mgmt_req) begin
            smb_req   <= 1'b1;
            smb_rnw   <= !mgmt_we;
            smb_cnt   <= CNT_W'(1);
            smb_offs  <= mgmt_offs;
            smb_wdata <= mgmt_wdata;
            st_q      <= ST_PT;
          end
        end
        ST_PT: begin
          if (smb_done) begin
            smb_req    <= 1'b0;
            mgmt_ack   <= 1'b1;
            mgmt_rdata <= rx_byte;
            mgmt_nak   <= smb_nak;
            st_q       <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // engine contract: a read byte never shares its cycle with completion
  p_byte_before_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(smb_done && smb_rvalid));

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (smb_req && !smb_done) |=> (smb_req && $stable(smb_offs) &&
                                $stable(smb_cnt) && $stable(smb_rnw)));

  p_req_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (smb_req && smb_done) |=> !smb_req);

  p_no_write_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |-> !reg_we);

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |=> ld_done);

  p_restore_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restore_defaults |-> (ld_done && ld_err));

  p_err_implies_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_err |-> ld_done);

  p_ack_after_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_ack |-> ld_done);

endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader #(
  parameter bit               HAS_STRAPS = 1'b1,
  parameter int               DEV_W      = 7,
  parameter logic [DEV_W-1:0] FIXED_DEV  = 7'h50,
  parameter int               OFFS_W     = 16,
  parameter int               CNT_W      = 3,
  parameter int               RCNT_W     = 16,
  parameter int               RADDR_W    = 16,
  parameter int               RDATA_W    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEV_W-1:0]   strap_dev,
  output logic               smb_req,
  output logic [DEV_W-1:0]   smb_dev,
  output logic               smb_rnw,
  output logic [CNT_W-1:0]   smb_cnt,
  output logic [OFFS_W-1:0]  smb_offs,
  output logic [7:0]         smb_wdata,
  input  logic               smb_rvalid,
  input  logic [7:0]         smb_rdata,
  input  logic               smb_done,
  input  logic               smb_nak,
  output logic               reg_we,
  output logic [RADDR_W-1:0] reg_addr,
  output logic [RDATA_W-1:0] reg_wdata,
  output logic               restore_defaults,
  output logic               ld_done,
  output logic               ld_err,
  input  logic               mgmt_req,
  input  logic               mgmt_we,
  input  logic [OFFS_W-1:0]  mgmt_offs,
  input  logic [7:0]         mgmt_wdata,
  output logic               mgmt_ack,
  output logic [7:0]         mgmt_rdata,
  output logic               mgmt_nak
);

  localparam int SH_W = RADDR_W + RDATA_W;

  logic [SH_W-1:0] sh_q;
  logic            csum_zero;
  logic            load_rx;

  cfg_ldr_devaddr #(
    .HAS_STRAPS (HAS_STRAPS),
    .DEV_W      (DEV_W),
    .FIXED_DEV  (FIXED_DEV)
  ) u_dev (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_dev (strap_dev),
    .dev       (smb_dev)
  );

  cfg_ldr_shift #(.SH_W(SH_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (smb_rvalid),
    .din   (smb_rdata),
    .sh    (sh_q)
  );

  cfg_ldr_csum u_csum (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (load_rx),
    .din   (smb_rdata),
    .zero  (csum_zero)
  );

  cfg_ldr_seq #(
    .OFFS_W  (OFFS_W),
    .CNT_W   (CNT_W),
    .RCNT_W  (RCNT_W),
    .RADDR_W (RADDR_W),
    .RDATA_W (RDATA_W)
  ) u_seq (
    .clk              (clk),
    .rst_n            (rst_n),
    .smb_req          (smb_req),
    .smb_rnw          (smb_rnw),
    .smb_cnt          (smb_cnt),
    .smb_offs         (smb_offs),
    .smb_wdata        (smb_wdata),
    .smb_rvalid       (smb_rvalid),
    .smb_done         (smb_done),
    .smb_nak          (smb_nak),
    .hdr_count        (sh_q[RCNT_W-1:0]),
    .rec_addr         (sh_q[SH_W-1 -: RADDR_W]),
    .rec_data         (sh_q[RDATA_W-1:0]),
    .rx_byte          (sh_q[7:0]),
    .csum_zero        (csum_zero),
    .load_rx          (load_rx),
    .reg_we           (reg_we),
    .reg_addr         (reg_addr),
    .reg_wdata        (reg_wdata),
    .restore_defaults (restore_defaults),
    .ld_done          (ld_done),
    .ld_err           (ld_err),
    .mgmt_req         (mgmt_req),
    .mgmt_we          (mgmt_we),
    .mgmt_offs        (mgmt_offs),
    .mgmt_wdata       (mgmt_wdata),
    .mgmt_ack         (mgmt_ack),
    .mgmt_rdata       (mgmt_rdata),
    .mgmt_nak         (mgmt_nak)
  );

endmodule

// File: tb/cfg_image_loader_tb_top.sv
module cfg_image_loader_tb_top;

  localparam int K_H = 0, K_R = 1, K_C = 2, K_P = 3;

  typedef struct {
    int          kind;
    int          offs;
    int          cnt;
    int          rnw;
    int          wd;
    int          ra;
    logic [31:0] rd;
    bit          zero_n;
  } txn_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  strap_dev = 7'h00;
  logic        smb_rvalid = 1'b0, smb_done = 1'b0, smb_nak = 1'b0;
  logic [7:0]  smb_rdata = 8'h00;
  logic        mgmt_req = 1'b0, mgmt_we = 1'b0;
  logic [15:0] mgmt_offs = 16'h0;
  logic [7:0]  mgmt_wdata = 8'h00;

  logic        smb_req, smb_rnw, reg_we, restore_defaults, ld_done, ld_err;
  logic        mgmt_ack, mgmt_nak;
  logic [6:0]  smb_dev;
  logic [2:0]  smb_cnt;
  logic [15:0] smb_offs, reg_addr;
  logic [7:0]  smb_wdata, mgmt_rdata;
  logic [31:0] reg_wdata;

  logic        fx_req, fx_rnw, fx_we, fx_rst, fx_done, fx_err, fx_ack, fx_nak;
  logic [6:0]  fx_dev;
  logic [2:0]  fx_cnt;
  logic [15:0] fx_offs, fx_raddr;
  logic [7:0]  fx_wdata, fx_rdata;
  logic [31:0] fx_rwdata;

  always #10 clk = ~clk;

  cfg_image_loader dut_i (
    .clk(clk), .rst_n(rst_n), .strap_dev(strap_dev),
    .smb_req(smb_req), .smb_dev(smb_dev), .smb_rnw(smb_rnw), .smb_cnt(smb_cnt),
    .smb_offs(smb_offs), .smb_wdata(smb_wdata), .smb_rvalid(smb_rvalid),
    .smb_rdata(smb_rdata), .smb_done(smb_done), .smb_nak(smb_nak),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .restore_defaults(restore_defaults), .ld_done(ld_done), .ld_err(ld_err),
    .mgmt_req(mgmt_req), .mgmt_we(mgmt_we), .mgmt_offs(mgmt_offs),
    .mgmt_wdata(mgmt_wdata), .mgmt_ack(mgmt_ack), .mgmt_rdata(mgmt_rdata),
    .mgmt_nak(mgmt_nak)
  );

  cfg_image_loader #(.HAS_STRAPS(1'b0)) dut_fixed_i (
    .clk(clk), .rst_n(rst_n), .strap_dev(strap_dev),
    .smb_req(fx_req), .smb_dev(fx_dev), .smb_rnw(fx_rnw), .smb_cnt(fx_cnt),
    .smb_offs(fx_offs), .smb_wdata(fx_wdata), .smb_rvalid(1'b0),
    .smb_rdata(8'h00), .smb_done(1'b0), .smb_nak(1'b0),
    .reg_we(fx_we), .reg_addr(fx_raddr), .reg_wdata(fx_rwdata),
    .restore_defaults(fx_rst), .ld_done(fx_done), .ld_err(fx_err),
    .mgmt_req(1'b0), .mgmt_we(1'b0), .mgmt_offs(16'h0),
    .mgmt_wdata(8'h00), .mgmt_ack(fx_ack), .mgmt_rdata(fx_rdata),
    .mgmt_nak(fx_nak)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] mem [0:255];
  txn_t q[$];
  int   bq[$];
  bit   exp_bad;
  int   exp_dev;
  int   txn_idx, nak_at = -1;
  bit   pt_nak = 0, just_rel = 0;
  int   eng_st = 0, eng_lat = 0;
  bit   eng_nak, eng_valid;
  txn_t eng_cur;

  bit e_we, e_restore, e_done, e_err, e_ack, e_nak, e_rdchk;
  int e_ra, e_rdbyte;
  logic [31:0] e_rd;
  bit n_we, n_restore, n_done, n_err, n_ack, n_nak, n_rdchk;
  int n_ra, n_rdbyte;
  logic [31:0] n_rd;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic clear_exp();
    {e_we, e_restore, e_done, e_err, e_ack, e_nak, e_rdchk} = '0;
    {n_we, n_restore, n_done, n_err, n_ack, n_nak, n_rdchk} = '0;
  endtask

  // one clock: compare outputs, then advance the engine model
  task automatic tick();
    @(negedge clk);
    e_we = n_we; e_ra = n_ra; e_rd = n_rd; n_we = 0;
    e_restore = n_restore; n_restore = 0;
    e_ack = n_ack; e_nak = n_nak; e_rdchk = n_rdchk; e_rdbyte = n_rdbyte; n_ack = 0;
    if (n_done) e_done = 1;
    if (n_err)  e_err = 1;
    n_done = 0; n_err = 0;

    chk(reg_we == e_we, "R5", "reg_we", reg_we, e_we);
    if (e_we) begin
      chk(reg_addr == e_ra[15:0], "R5", "reg_addr", reg_addr, e_ra);
      chk(reg_wdata == e_rd, "R5", "reg_wdata", reg_wdata, e_rd);
    end
    chk(restore_defaults == e_restore, "R7", "restore_defaults", restore_defaults, e_restore);
    chk(ld_done == e_done, "R6", "ld_done", ld_done, e_done);
    chk(ld_err == e_err, "R8", "ld_err", ld_err, e_err);
    chk(mgmt_ack == e_ack, "R10", "mgmt_ack", mgmt_ack, e_ack);
    if (e_ack) begin
      chk(mgmt_nak == e_nak, "R11", "mgmt_nak", mgmt_nak, e_nak);
      if (e_rdchk) chk(mgmt_rdata == e_rdbyte[7:0], "R10", "mgmt_rdata", mgmt_rdata, e_rdbyte);
    end
    chk(fx_dev == 7'h50, "R3", "fixed smb_dev", fx_dev, 7'h50);
    if (!rst_n) chk(smb_req == 1'b0, "R1", "smb_req in reset", smb_req, 0);
    if (just_rel) begin
      chk(smb_req == 1'b1, "R1", "smb_req after release", smb_req, 1);
      just_rel = 0;
    end
    if (mgmt_ack && mgmt_req) mgmt_req = 1'b0;

    smb_rvalid = 0; smb_done = 0; smb_nak = 0; smb_rdata = 8'h00;
    if (!rst_n) eng_st = 0;
    else begin
      case (eng_st)
        0: if (smb_req) begin
          eng_valid = (q.size() != 0);
          if (!eng_valid) begin
            chk(0, "R8", "unexpected request at offset", smb_offs, 0);
          end else begin
            string tg;
            eng_cur = q.pop_front();
            tg = (eng_cur.kind == K_P) ? (eng_cur.rnw ? "R10" : "R11") :
                 (eng_cur.kind == K_C && eng_cur.zero_n) ? "R9" : "R4";
            chk(smb_dev == exp_dev[6:0], "R2", "smb_dev", smb_dev, exp_dev);
            chk(smb_rnw == eng_cur.rnw[0], tg, "smb_rnw", smb_rnw, eng_cur.rnw);
            chk(smb_cnt == eng_cur.cnt[2:0], tg, "smb_cnt", smb_cnt, eng_cur.cnt);
            chk(smb_offs == eng_cur.offs[15:0], tg, "smb_offs", smb_offs, eng_cur.offs);
            if (!eng_cur.rnw)
              chk(smb_wdata == eng_cur.wd[7:0], "R11", "smb_wdata", smb_wdata, eng_cur.wd);
          end
          eng_nak = (txn_idx == nak_at) || (eng_valid && eng_cur.kind == K_P && pt_nak);
          txn_idx++;
          bq.delete();
          if (smb_rnw) for (int k = 0; k < int'(smb_cnt); k++)
            bq.push_back(int'(mem[(int'(smb_offs) + k) & 255]));
          eng_lat = 2;
          eng_st = 1;
        end
        1: begin
          eng_lat--;
          if (eng_lat == 0) eng_st = 2;
        end
        2: if (!eng_nak && bq.size() != 0) begin
          smb_rvalid = 1;
          smb_rdata = bq.pop_front();
        end else begin
          smb_done = 1;
          smb_nak = eng_nak;
          eng_st = 3;
          if (eng_valid) begin
            if (eng_nak) begin
              if (eng_cur.kind == K_P) begin
                n_ack = 1; n_nak = 1; n_rdchk = 0;
              end else begin
                n_done = 1; n_err = 1; n_restore = 1;
                q.delete();
              end
            end else begin
              case (eng_cur.kind)
                K_R: begin n_we = 1; n_ra = eng_cur.ra; n_rd = eng_cur.rd; end
                K_C: begin n_done = 1; if (exp_bad) begin n_err = 1; n_restore = 1; end end
                K_P: begin
                  n_ack = 1; n_nak = 0;
                  if (eng_cur.rnw) begin
                    n_rdchk = 1; n_rdbyte = int'(mem[eng_cur.offs & 255]);
                  end else begin
                    n_rdchk = 0; mem[eng_cur.offs & 255] = eng_cur.wd[7:0];
                  end
                end
                default: ;
              endcase
            end
          end
        end
        default: begin
          chk(smb_req == 1'b0, "R12", "smb_req after done", smb_req, 0);
          eng_st = 0;
        end
      endcase
    end
  endtask

  task automatic build_image(input int n, input int seed, input bit bad);
    int sum, o, ra;
    logic [31:0] rd;
    for (int k = 0; k < 256; k++) mem[k] = 8'h00;
    mem[0] = 8'(n >> 8);
    mem[1] = 8'(n);
    for (int i = 0; i < n; i++) begin
      o  = 2 + 6 * i;
      ra = 16'h0040 + i * 4 + seed;
      rd = 32'h5A000000 + i * 32'h00010203 + seed * 32'h11;
      mem[o]   = 8'(ra >> 8);  mem[o+1] = 8'(ra);
      mem[o+2] = rd[31:24];    mem[o+3] = rd[23:16];
      mem[o+4] = rd[15:8];     mem[o+5] = rd[7:0];
    end
    sum = 0;
    for (int k = 0; k < 2 + 6 * n; k++) sum += int'(mem[k]);
    mem[2 + 6 * n] = 8'((256 - (sum % 256)) % 256 + (bad ? 1 : 0));
  endtask

  // derive the whole expected transaction list from the EEPROM contents
  task automatic expect_from_mem();
    txn_t t;
    int n, o, sum;
    n = int'(mem[0]) * 256 + int'(mem[1]);
    t = '{kind:K_H, offs:0, cnt:2, rnw:1, wd:0, ra:0, rd:32'h0, zero_n:0};
    q.push_back(t);
    for (int i = 0; i < n; i++) begin
      o = 2 + 6 * i;
      t = '{kind:K_R, offs:o, cnt:6, rnw:1, wd:0,
            ra:int'(mem[o]) * 256 + int'(mem[o+1]),
            rd:{mem[o+2], mem[o+3], mem[o+4], mem[o+5]}, zero_n:0};
      q.push_back(t);
    end
    t = '{kind:K_C, offs:2 + 6 * n, cnt:1, rnw:1, wd:0, ra:0, rd:32'h0, zero_n:(n == 0)};
    q.push_back(t);
    sum = 0;
    for (int k = 0; k <= 2 + 6 * n; k++) sum += int'(mem[k]);
    exp_bad = (sum % 256) != 0;
  endtask

  task automatic raise_pt(input bit we, input int offs, input int wd);
    txn_t t;
    t = '{kind:K_P, offs:offs, cnt:1, rnw:int'(!we), wd:wd, ra:0, rd:32'h0, zero_n:0};
    q.push_back(t);
    mgmt_we = we; mgmt_offs = 16'(offs); mgmt_wdata = 8'(wd);
    mgmt_req = 1'b1;
  endtask

  task automatic pt_op(input bit we, input int offs, input int wd);
    raise_pt(we, offs, wd);
    for (int i = 0; i < 200 && mgmt_req; i++) tick();
    tick();
  endtask

  task automatic assert_reset(input logic [6:0] s);
    rst_n = 1'b0; strap_dev = s;
    q.delete(); clear_exp(); eng_st = 0;
    repeat (3) tick();
  endtask

  task automatic release_reset();
    exp_dev = int'(strap_dev); txn_idx = 0;
    rst_n = 1'b1; just_rel = 1;
    tick();
  endtask

  task automatic run_load();
    for (int i = 0; i < 2000 && !(e_done && eng_st == 0 && q.size() == 0 && !mgmt_req); i++)
      tick();
    repeat (3) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int fixv;
    // A: three records, straps moved mid-load, pass-through held off (R1 R2 R4 R5 R6 R10)
    assert_reset(7'h52);
    build_image(3, 1, 1'b0);
    expect_from_mem();
    raise_pt(1'b0, 3, 0);
    release_reset();
    repeat (10) tick();
    strap_dev = 7'h11;
    run_load();

    // B: checksum off by one (R7), then reprogram through the port (R11, R10)
    assert_reset(7'h33);
    build_image(2, 2, 1'b1);
    expect_from_mem();
    release_reset();
    run_load();
    fixv = (int'(mem[14]) + 255) % 256;
    pt_op(1'b1, 14, fixv);
    pt_op(1'b0, 14, 0);

    // C: reload the repaired image with new straps (R6, R2)
    assert_reset(7'h57);
    expect_from_mem();
    release_reset();
    run_load();

    // D: empty image, checksum read at offset 2 (R9)
    assert_reset(7'h50);
    build_image(0, 0, 1'b0);
    expect_from_mem();
    release_reset();
    run_load();

    // E: no acknowledge on the second record (R8)
    assert_reset(7'h21);
    build_image(3, 3, 1'b0);
    expect_from_mem();
    nak_at = 2;
    release_reset();
    run_load();
    repeat (6) tick();
    nak_at = -1;

    // F: pass-through with and without acknowledge failure (R11)
    pt_nak = 1;
    pt_op(1'b0, 0, 0);
    pt_nak = 0;
    pt_op(1'b1, 5, 8'h9C);
    pt_op(1'b0, 5, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule